// File: doc/BRIEF.md
# Gated programmable clock divider

One clock slice. A one-bit select picks one of two source clocks. An integer divider divides the chosen clock, and an enable gate drives the divided result onto `clk_o`. A small register port on a configuration clock sets three things: the gate enable, the source select and a divider control word. The ratio in use has two possible sources. One is a default code fixed per instance by a parameter. The other is a programmed field in the control word, and a source bit in that word chooses between the two.

The ratio field accepts a dense range of small codes plus a few sparse large codes. A code outside that set makes the slice divide by 1 and sets a sticky error flag. A new ratio reaches the divider through a toggle handshake. The divider adopts it only at the end of the current output period, so the output never shows a truncated pulse. The gate enable is resynchronised to the source clock and changes only while the output is low.

Top module: `gated_clk_divider`

## Requirements
- R1: After `rst_ni` is asserted, every register reads 0. `clk_o` stays low, `illegal_o` is 0 and `div_ratio_o` equals `DEF_CODE`+1.
- R2: The register addresses are 0 for enable (bit 0), 1 for select (bit 0) and 2 for the divider control word. In the control word the ratio field is `RATIO_W` bits wide starting at bit 16, and bit 3 is the source bit. A read returns the fields as written, with all other bits reading 0.
- R3: With source bit 0, the divider uses `DEF_CODE` whatever the field holds. With source bit 1, it uses the programmed field.
- R4: A code n in 0..31 divides the source clock by n+1. Code 0 passes the source clock through unchanged.
- R5: Codes 127, 255, 511 and 65535 divide by 128, 256, 512 and 65536, where `RATIO_W` is wide enough to hold them.
- R6: A selected code outside the legal set divides by 1. Writing such a code with source bit 1 sets `illegal_o`, which stays set until reset.
- R7: With the enable bit at 0, `clk_o` is held low. The synchronised gate changes state only while the divided output is low.
- R8: Select value 0 drives the divider from `clk_a_i`, and value 1 from `clk_b_i`.
- R9: A ratio change takes effect only at an output period boundary. No high pulse is shorter than the shorter high phase of the old and new ratios, and the same holds for low pulses.
- R10: For a divide ratio N of at least 2, the output is high for floor(N/2) source cycles and low for the rest of each period.
- R11: `div_ratio_o` reports the divide ratio the current configuration selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_a_i | input | 1 | Source clock for select value 0 |
| clk_b_i | input | 1 | Source clock for select value 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| clk_o | output | 1 | Divided, gated output clock |
| div_ratio_o | output | 17 | Divide ratio selected by the configuration |
| illegal_o | output | 1 | Sticky illegal-code flag |

## Verification
`rd_data_o`, `div_ratio_o` and `illegal_o` follow a write at the very next configuration edge, so the bench reads them one time unit after the falling edge that follows the write. `clk_o` follows a ratio write only after three source edges of toggle synchronisation plus the rest of the old period. It follows an enable change after two source edges plus a falling edge. The bench therefore waits more than twice the old ratio before it measures. It then counts output rising edges and high samples over a window that is a whole multiple of the expected period, so the result does not depend on phase. The boundary check is different: it starts measuring at once and bounds the shortest high and low runs.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int FIELD_LSB = 16;  // ratio field position in the control word
  localparam int SRC_BIT   = 3;   // 1: programmed field, 0: default code
  localparam int CODE_W    = 16;
  localparam int N_W       = 17;  // divide ratio up to 65536

  typedef enum logic [1:0] {
    ADDR_EN  = 2'd0,
    ADDR_SEL = 2'd1,
    ADDR_DIV = 2'd2
  } reg_addr_e;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c < 16'd32) || (c == 16'd127) || (c == 16'd255) ||
           (c == 16'd511) || (c == 16'hFFFF);
  endfunction

  function automatic logic [N_W-1:0] code_to_n(input logic [CODE_W-1:0] c);
    return code_ok(c) ? (N_W'(c) + 17'd1) : 17'd1;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W  = 8,
  parameter int DEF_CODE = 15,
  parameter int HAS_SEL  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              en_o,
  output logic              sel_o,
  output logic [CODE_W-1:0] eff_code_o,
  output logic              upd_tgl_o,
  output logic              illegal_o
);
  logic               en_q, sel_q, prog_q, tgl_q, illegal_q;
  logic [RATIO_W-1:0] field_q, wr_field;
  logic [CODE_W-1:0]  wr_code;
  logic               unused_wr;

  assign wr_field  = wr_data_i[FIELD_LSB +: RATIO_W];
  assign wr_code   = CODE_W'(wr_field);
  assign unused_wr = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      sel_q     <= 1'b0;
      prog_q    <= 1'b0;
      field_q   <= '0;
      tgl_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_EN:  en_q  <= wr_data_i[0];
        ADDR_SEL: sel_q <= (HAS_SEL != 0) && wr_data_i[0];
        ADDR_DIV: begin
          field_q <= wr_field;
          prog_q  <= wr_data_i[SRC_BIT];
          tgl_q   <= ~tgl_q;
          if (wr_data_i[SRC_BIT] && !code_ok(wr_code)) illegal_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_EN:  rd_data_o[0] = en_q;
      ADDR_SEL: rd_data_o[0] = sel_q;
      ADDR_DIV: begin
        rd_data_o[FIELD_LSB +: RATIO_W] = field_q;
        rd_data_o[SRC_BIT]              = prog_q;
      end
      default: ;
    endcase
  end

  assign en_o       = en_q;
  assign sel_o      = sel_q;
  assign eff_code_o = prog_q ? CODE_W'(field_q) : CODE_W'(DEF_CODE);
  assign upd_tgl_o  = tgl_q;
  assign illegal_o  = illegal_q;

  assert_illegal_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |=> illegal_q);
  assert_toggle_on_div_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_DIV) |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int DEF_CODE = 15
) (
  input  logic              clk_i,     // selected source clock
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,    // configuration domain, stable after toggle
  input  logic              upd_tgl_i,
  output logic              div_q_o,
  output logic              bypass_o
);
  localparam logic [N_W-1:0] DEF_N = code_to_n(CODE_W'(DEF_CODE));

  logic [2:0]     t_sync;
  logic [N_W-1:0] tgt_n, cur_n, cnt, cnt_nxt, n_use, half;
  logic           wrap, div_q;

  assign wrap    = (cnt == cur_n - 17'd1);
  assign n_use   = wrap ? tgt_n : cur_n;
  assign cnt_nxt = wrap ? '0 : cnt + 17'd1;
  assign half    = n_use >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_sync <= '0;
      tgt_n  <= DEF_N;
      cur_n  <= DEF_N;
      cnt    <= '0;
      div_q  <= (DEF_N >= 17'd2);
    end else begin
      t_sync <= {t_sync[1:0], upd_tgl_i};
      if (t_sync[2] ^ t_sync[1]) tgt_n <= code_to_n(code_i);
      if (wrap) cur_n <= tgt_n;  // adopt new ratio only at period boundary
      cnt   <= cnt_nxt;
      div_q <= (cnt_nxt < half);
    end
  end

  assign div_q_o  = div_q;
  assign bypass_o = (cur_n == 17'd1);

  assert_cnt_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < cur_n);
  assert_swap_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_n) |-> (cnt == '0));
  assert_rise_at_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_q) |-> (cnt == '0));
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk_i,   // selected source clock
  input  logic rst_ni,
  input  logic en_i,    // configuration domain
  input  logic div_q_i,
  input  logic bypass_i,
  output logic clk_o
);
  logic en_s1, en_s2, gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1 <= 1'b0;
      en_s2 <= 1'b0;
    end else begin
      en_s1 <= en_i;
      en_s2 <= en_s1;
    end
  end

  // falling edge update: source clock low, divided output must be low too
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  gate_q <= 1'b0;
    else if (bypass_i || !div_q_i) gate_q <= en_s2;
  end

  assign clk_o = gate_q & (bypass_i ? clk_i : div_q_i);

  assert_gate_when_low_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> $past(bypass_i || !div_q_i));
  assert_off_low_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !gate_q |-> !clk_o);
endmodule

// File: rtl/gated_clk_divider.sv
module gated_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W  = 8,
  parameter int DEF_CODE = 15,
  parameter int HAS_SEL  = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clk_a_i,
  input  logic        clk_b_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        clk_o,
  output logic [16:0] div_ratio_o,
  output logic        illegal_o
);
  logic              en, sel, upd_tgl, src_clk, div_q, bypass;
  logic [CODE_W-1:0] eff_code;

  clkdiv_regs #(.RATIO_W(RATIO_W), .DEF_CODE(DEF_CODE), .HAS_SEL(HAS_SEL)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .en_o(en), .sel_o(sel), .eff_code_o(eff_code), .upd_tgl_o(upd_tgl),
    .illegal_o(illegal_o)
  );

  generate
    if (HAS_SEL != 0) begin : g_mux
      assign src_clk = sel ? clk_b_i : clk_a_i;
    end else begin : g_single
      logic unused_sel;
      assign unused_sel = sel ^ clk_b_i;
      assign src_clk    = clk_a_i;
    end
  endgenerate

  clkdiv_counter #(.DEF_CODE(DEF_CODE)) u_counter (
    .clk_i(src_clk), .rst_ni(rst_ni), .code_i(eff_code), .upd_tgl_i(upd_tgl),
    .div_q_o(div_q), .bypass_o(bypass)
  );

  clkdiv_gate u_gate (
    .clk_i(src_clk), .rst_ni(rst_ni), .en_i(en), .div_q_i(div_q),
    .bypass_i(bypass), .clk_o(clk_o)
  );

  assign div_ratio_o = code_to_n(eff_code);
endmodule

// File: tb/gated_clk_divider_bench.sv
module gated_clk_divider_bench;
  logic        clk = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        clk_o, illegal;
  logic [16:0] ratio;
  int n_chk = 0, n_fail = 0, rise_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;                 // 250 MHz
  always @(posedge clk) clk_b <= ~clk_b; // half-rate second source
  always @(posedge clk_o) rise_cnt++;

  gated_clk_divider u_gated_clk_divider (
    .clk_i(clk), .rst_ni(rst_n), .clk_a_i(clk), .clk_b_i(clk_b),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .clk_o(clk_o),
    .div_ratio_o(ratio), .illegal_o(illegal)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_min(input string req, input string what, input int act, input int lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] dword(input int code, input bit src);
    return (32'(code) << 16) | (src ? 32'h8 : 32'h0);
  endfunction

  // samples at falling edges; edges counted between the first and last sample
  task automatic meas(input int cycles, output int rises, output int highs,
                      output int min_hi, output int min_lo);
    int start, run, prev, v;
    bit seen;
    highs = 0; min_hi = 1 << 30; min_lo = 1 << 30; run = 0; prev = 0; seen = 0;
    @(negedge clk);
    start = rise_cnt;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      v = int'(clk_o);
      highs += v;
      if (i == 0) begin prev = v; run = 1; end
      else if (v == prev) run++;
      else begin
        if (seen) begin
          if (prev == 1 && run < min_hi) min_hi = run;
          if (prev == 0 && run < min_lo) min_lo = run;
        end
        seen = 1; prev = v; run = 1;
      end
    end
    rises = rise_cnt - start;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    int r, h, mh, ml;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      chk("R1", "register after reset", int'(d), 0);
    end
    chk("R1", "ratio after reset", int'(ratio), 16);
    chk("R1", "illegal after reset", int'(illegal), 0);
    meas(32, r, h, mh, ml);
    chk("R1", "edges while disabled", r, 0);
    chk("R1", "high samples while disabled", h, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R2", "enable readback", int'(d), 1);
    wr(2'd2, dword(5, 1));
    rd(2'd2, d); chk("R2", "control word readback", int'(d), 32'h0005_0008);
    chk("R11", "ratio after code 5", int'(ratio), 6);
    wr(2'd2, dword(4, 0));
    rd(2'd2, d); chk("R2", "control word, source bit 0", int'(d), 32'h0004_0000);
    chk("R3", "source bit 0 picks default", int'(ratio), 16);
  endtask

  task automatic t_default;
    int r, h, mh, ml;
    idle(60);
    meas(64, r, h, mh, ml);
    chk("R3", "default divide-by-16 edges", r, 4);
    chk("R10", "default divide-by-16 high samples", h, 32);
  endtask

  task automatic t_dense;
    int r, h, mh, ml;
    wr(2'd2, dword(4, 1)); chk("R11", "ratio code 4", int'(ratio), 5);
    idle(40); meas(50, r, h, mh, ml);
    chk("R4", "divide-by-5 edges", r, 10);
    chk("R10", "divide-by-5 high samples", h, 20);
    wr(2'd2, dword(1, 1)); idle(20); meas(50, r, h, mh, ml);
    chk("R4", "divide-by-2 edges", r, 25);
    chk("R10", "divide-by-2 high samples", h, 25);
    wr(2'd2, dword(0, 1)); idle(20); meas(50, r, h, mh, ml);
    chk("R4", "code 0 passthrough edges", r, 50);
    chk("R11", "ratio code 0", int'(ratio), 1);
    wr(2'd2, dword(31, 1)); idle(20); meas(64, r, h, mh, ml);
    chk("R4", "divide-by-32 edges", r, 2);
    chk("R10", "divide-by-32 high samples", h, 32);
  endtask

  task automatic t_sparse;
    int r, h, mh, ml;
    wr(2'd2, dword(127, 1)); chk("R5", "ratio code 127", int'(ratio), 128);
    idle(80); meas(256, r, h, mh, ml);
    chk("R5", "divide-by-128 edges", r, 2);
    chk("R10", "divide-by-128 high samples", h, 128);
    wr(2'd2, dword(255, 1)); chk("R5", "ratio code 255", int'(ratio), 256);
    idle(300); meas(512, r, h, mh, ml);
    chk("R5", "divide-by-256 edges", r, 2);
    chk("R10", "divide-by-256 high samples", h, 256);
  endtask

  task automatic t_illegal;
    int r, h, mh, ml;
    wr(2'd2, dword(200, 0));
    chk("R6", "illegal field unused, flag clear", int'(illegal), 0);
    chk("R3", "illegal field unused, default ratio", int'(ratio), 16);
    wr(2'd2, dword(100, 1));
    chk("R6", "illegal code sets flag", int'(illegal), 1);
    chk("R6", "illegal code ratio", int'(ratio), 1);
    idle(540); meas(40, r, h, mh, ml);
    chk("R6", "illegal code divides by 1", r, 40);
    wr(2'd2, dword(2, 1));
    chk("R6", "flag sticky after legal code", int'(illegal), 1);
    idle(20); meas(30, r, h, mh, ml);
    chk("R4", "divide-by-3 edges", r, 10);
    chk("R10", "divide-by-3 high samples", h, 10);
  endtask

  task automatic t_gate;
    int r, h, mh, ml;
    wr(2'd2, dword(0, 1)); idle(10);
    wr(2'd0, 32'h0); idle(10); meas(40, r, h, mh, ml);
    chk("R7", "passthrough gated off edges", r, 0);
    wr(2'd2, dword(1, 1)); idle(20); meas(40, r, h, mh, ml);
    chk("R7", "divided gated off edges", r, 0);
    chk("R7", "divided gated off high samples", h, 0);
    wr(2'd0, 32'h1); idle(20); meas(40, r, h, mh, ml);
    chk("R7", "re-enabled edges", r, 20);
  endtask

  task automatic t_select;
    int r, h, mh, ml;
    logic [31:0] d;
    wr(2'd1, 32'h1); rd(2'd1, d); chk("R2", "select readback", int'(d), 1);
    idle(20); meas(64, r, h, mh, ml);
    chk("R8", "second source divide-by-2 edges", r, 16);
    wr(2'd1, 32'h0); idle(20); meas(64, r, h, mh, ml);
    chk("R8", "first source divide-by-2 edges", r, 32);
  endtask

  task automatic t_boundary;
    int r, h, mh, ml;
    wr(2'd2, dword(15, 1)); idle(60);
    wr(2'd2, dword(4, 1));
    meas(200, r, h, mh, ml);
    chk_min("R9", "shortest high run across change", mh, 2);
    chk_min("R9", "shortest low run across change", ml, 3);
    wr(2'd2, dword(15, 1));
    meas(200, r, h, mh, ml);
    chk_min("R9", "shortest high run, 5 to 16", mh, 2);
    chk_min("R9", "shortest low run, 5 to 16", ml, 3);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_default();
    t_dense();
    t_sparse();
    t_illegal();
    t_gate();
    t_select();
    t_boundary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule